// File: doc/BRIEF.md
# Prescaled Compare-Match Event Timer

This block is one 16-bit timer channel for a slow reference clock. A strobe, `ref_tick`, marks each reference period (nominally 32.768 kHz) in the fast bus-clock domain. A power-of-two prescaler selected by a scale field turns those strobes into counting ticks. The ticks advance a software-writable up-counter, and the counter is compared against two compare registers. Each match sets a sticky flag in the control word. A match on the second comparator also ends the interval: the counter starts again from zero, and when the event mode asks for it an interrupt level is raised.

Software drives the block through a plain synchronous register bus with a write strobe, a read strobe and registered read data. The bus is a control path, not a data stream, so it has no valid/ready handshake and no back-pressure. A write is accepted in the cycle its strobe is high. Read data appears one clock after the read strobe and holds until the next read.

The flags sit in the same word as the enable, scale and mode fields and are cleared by writing 1. A single write can therefore stop the counter and acknowledge both matches at once.

Top module: `evt_match_timer`

## Requirements
- R1: After reset, every register reads 0 and `irq` is low.
- R2: The counter changes only on a counting tick while the enable bit (control bit 15) is 1, or on a bus write to the counter.
- R3: The prescaler divides `ref_tick` strobes by 2^scale, where scale is control bits [3:0]. The divider restarts whenever the counter is written and whenever enable goes from 0 to 1, so the first count after either event needs a full 2^scale strobes.
- R4: Scale values above 8 behave as 8, which divides by 256.
- R5: Register map in word addresses: 0 = compare-1, 1 = compare-2, 2 = counter, 3 = control. The counter reads back its live value, and a write to it loads that value.
- R6: On a tick where the counter equals compare-2, the compare-2 flag (control bit 14) sets and the counter becomes 0 instead of incrementing.
- R7: On a tick where the counter equals compare-1, the compare-1 flag (control bit 13) sets and counting continues normally.
- R8: Writing 1 to a flag bit clears it. Writing 0 leaves it unchanged. One write with enable 0 and both flag bits 1 stops counting and clears both flags.
- R9: `irq` equals the compare-2 flag AND (event mode, control bits [9:8], == 3). It stays high until the flag is cleared.
- R10: Any compare-2 value from 0x000F to 0xFFFE gives exactly one match per interval of compare-2 + 1 ticks.
- R11: If no match occurs, the counter wraps from 0xFFFF to 0.
- R12: If a match and a clearing write to the same flag land on the same clock edge, the flag is left set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and logic clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_tick | input | 1 | One-cycle strobe per reference-clock period |
| bus_addr | input | 2 | Register word address |
| bus_wdata | input | 16 | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 16 | Registered read data |
| irq | output | 1 | Compare-2 interrupt level |

## Verification
The hardest case to reach from the ports is a flag-clearing bus write that lands on the same clock edge as a compare-2 match. The bench gets there by holding `ref_tick` low while it parks the counter one tick short of the match. It then raises `ref_tick` in the same cycle as the clearing write. The long intervals at the edges of the compare range are reached by loading the counter next to the compare value rather than counting up to it. The divider-restart rule is checked by writing the counter partway through a prescaled period.

// File: rtl/evt_pkg.sv
package evt_pkg;
  localparam int CNT_W     = 16;
  localparam int SCALE_W   = 4;
  localparam int MAX_SCALE = 8;
  localparam int ADDR_W    = 2;
  localparam int NUM_CMP   = 2;

  // control word bit positions
  localparam int EN_BIT    = 15;
  localparam int F2_BIT    = 14;
  localparam int F1_BIT    = 13;
  localparam int MODE_LO   = 8;
  localparam int MODE_W    = 2;

  typedef enum logic [ADDR_W-1:0] {
    A_CMP1 = 2'd0,
    A_CMP2 = 2'd1,
    A_CNT  = 2'd2,
    A_CTRL = 2'd3
  } reg_addr_e;

  localparam logic [MODE_W-1:0] MODE_IRQ = 2'b11;
endpackage

// File: rtl/evt_prescaler.sv
module evt_prescaler #(
  parameter int SCALE_W   = 4,
  parameter int MAX_SCALE = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ref_tick,
  input  logic               run,
  input  logic               restart,
  input  logic [SCALE_W-1:0] scale,
  output logic               tick_o
);
  localparam int DIV_W = (MAX_SCALE > 0) ? MAX_SCALE : 1;

  logic [SCALE_W-1:0] eff_scale;
  logic [DIV_W:0]     limit_w;
  logic [DIV_W-1:0]   limit;
  logic [DIV_W-1:0]   div_q;
  logic               at_limit;

  always_comb begin
    if (scale > SCALE_W'(MAX_SCALE)) eff_scale = SCALE_W'(MAX_SCALE);
    else                             eff_scale = scale;
    limit_w = ((DIV_W+1)'(1) << eff_scale) - (DIV_W+1)'(1);
    limit   = limit_w[DIV_W-1:0];
  end

  generate
    if (MAX_SCALE == 0) begin : g_nodiv
      assign at_limit = 1'b1;
      always_ff @(posedge clk) div_q <= '0;
    end else begin : g_div
      assign at_limit = (div_q == limit);
      always_ff @(posedge clk) begin
        if (!rst_n || restart)      div_q <= '0;
        else if (run && ref_tick) begin
          if (at_limit) div_q <= '0;
          else          div_q <= div_q + 1'b1;
        end
      end
    end
  endgenerate

  assign tick_o = run && ref_tick && !restart && at_limit;

  // Back-to-back ticks are only possible at divisor 1
  assert_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> (!tick_o || $past(limit) == '0 || limit == '0));
endmodule

// File: rtl/evt_counter.sv
module evt_counter #(
  parameter int CNT_W   = 16,
  parameter int NUM_CMP = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic               cnt_wr,
  input  logic [CNT_W-1:0]   wdata,
  input  logic [NUM_CMP-1:0] cmp_wr,
  output logic [CNT_W-1:0]   count,
  output logic [CNT_W-1:0]   cmp_val [NUM_CMP],
  output logic [NUM_CMP-1:0] hit
);
  // compare registers and their match detectors
  for (genvar i = 0; i < NUM_CMP; i++) begin : g_cmp
    always_ff @(posedge clk) begin
      if (!rst_n)         cmp_val[i] <= '0;
      else if (cmp_wr[i]) cmp_val[i] <= wdata;
    end
    assign hit[i] = tick && !cnt_wr && (count == cmp_val[i]);
  end

  // the last comparator terminates the interval
  always_ff @(posedge clk) begin
    if (!rst_n)                 count <= '0;
    else if (cnt_wr)            count <= wdata;
    else if (hit[NUM_CMP-1])    count <= '0;
    else if (tick)              count <= count + 1'b1;
  end

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !cnt_wr) |=> $stable(count));
  assert_match_wraps_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !cnt_wr && count == cmp_val[NUM_CMP-1]) |=> count == '0);
  assert_wrap_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !cnt_wr && count == '1) |=> count == '0);
endmodule

// File: rtl/evt_ctrl.sv
module evt_ctrl
  import evt_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ctrl_wr,
  input  logic [CNT_W-1:0]   wdata,
  input  logic [NUM_CMP-1:0] hit,
  output logic               en,
  output logic [SCALE_W-1:0] scale,
  output logic [MODE_W-1:0]  mode,
  output logic [NUM_CMP-1:0] flags,
  output logic               en_rise,
  output logic [CNT_W-1:0]   ctrl_word
);
  logic [NUM_CMP-1:0] clr;

  assign clr     = ctrl_wr ? {wdata[F2_BIT], wdata[F1_BIT]} : '0;
  assign en_rise = ctrl_wr && wdata[EN_BIT] && !en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en    <= 1'b0;
      scale <= '0;
      mode  <= '0;
    end else if (ctrl_wr) begin
      en    <= wdata[EN_BIT];
      scale <= wdata[SCALE_W-1:0];
      mode  <= wdata[MODE_LO +: MODE_W];
    end
  end

  // sticky flags: a match wins over a same-cycle clear
  always_ff @(posedge clk) begin
    if (!rst_n) flags <= '0;
    else        flags <= (flags & ~clr) | hit;
  end

  always_comb begin
    ctrl_word                   = '0;
    ctrl_word[EN_BIT]           = en;
    ctrl_word[F2_BIT]           = flags[1];
    ctrl_word[F1_BIT]           = flags[0];
    ctrl_word[MODE_LO +: MODE_W] = mode;
    ctrl_word[SCALE_W-1:0]      = scale;
  end

  assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (flags[1] && !clr[1]) |=> flags[1]);
  assert_flag_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags[1]) |-> $past(hit[1]));
  assert_set_wins_R12: assert property (@(posedge clk) disable iff (!rst_n)
    hit[1] |=> flags[1]);
endmodule

// File: rtl/evt_match_timer.sv
module evt_match_timer
  import evt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_tick,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CNT_W-1:0]  bus_wdata,
  input  logic              bus_wr,
  input  logic              bus_rd,
  output logic [CNT_W-1:0]  bus_rdata,
  output logic              irq
);
  logic               wr_cnt, wr_ctrl;
  logic [NUM_CMP-1:0] wr_cmp;
  logic               en, en_rise, tick;
  logic [SCALE_W-1:0] scale;
  logic [MODE_W-1:0]  mode;
  logic [NUM_CMP-1:0] flags, hit;
  logic [CNT_W-1:0]   count, ctrl_word;
  logic [CNT_W-1:0]   cmp_val [NUM_CMP];

  // address decode
  assign wr_cnt    = bus_wr && (bus_addr == A_CNT);
  assign wr_ctrl   = bus_wr && (bus_addr == A_CTRL);
  assign wr_cmp[0] = bus_wr && (bus_addr == A_CMP1);
  assign wr_cmp[1] = bus_wr && (bus_addr == A_CMP2);

  evt_ctrl u_ctrl (
    .clk, .rst_n, .ctrl_wr(wr_ctrl), .wdata(bus_wdata), .hit,
    .en, .scale, .mode, .flags, .en_rise, .ctrl_word
  );

  evt_prescaler #(.SCALE_W(SCALE_W), .MAX_SCALE(MAX_SCALE)) u_pre (
    .clk, .rst_n, .ref_tick, .run(en), .restart(wr_cnt || en_rise),
    .scale, .tick_o(tick)
  );

  evt_counter #(.CNT_W(CNT_W), .NUM_CMP(NUM_CMP)) u_cnt (
    .clk, .rst_n, .tick, .cnt_wr(wr_cnt), .wdata(bus_wdata),
    .cmp_wr(wr_cmp), .count, .cmp_val, .hit
  );

  always_ff @(posedge clk) begin
    if (!rst_n) bus_rdata <= '0;
    else if (bus_rd) begin
      unique case (bus_addr)
        A_CMP1:  bus_rdata <= cmp_val[0];
        A_CMP2:  bus_rdata <= cmp_val[1];
        A_CNT:   bus_rdata <= count;
        default: bus_rdata <= ctrl_word;
      endcase
    end
  end

  assign irq = flags[1] && (mode == MODE_IRQ);

  assert_irq_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !wr_ctrl) |=> irq);
  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |=> (!irq && bus_rdata == '0));
endmodule

// File: tb/evt_match_timer_bench.sv
module evt_match_timer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ref_tick = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [15:0] bus_rdata;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  evt_match_timer u_evt_match_timer (
    .clk, .rst_n, .ref_tick, .bus_addr, .bus_wdata, .bus_wr, .bus_rd,
    .bus_rdata, .irq
  );

  localparam logic [1:0] AC1 = 2'd0, AC2 = 2'd1, ACNT = 2'd2, ACTL = 2'd3;

  function automatic logic [15:0] ctl(input logic en, input logic c2,
      input logic c1, input logic [1:0] mode, input logic [3:0] sc);
    return {en, c2, c1, 3'b000, mode, 4'b0000, sc};
  endfunction

  task automatic check(input string req, input logic [15:0] act,
                       input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic pulse(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); ref_tick = 1'b1;
      @(negedge clk); ref_tick = 1'b0;
    end
  endtask

  task automatic prep(input logic [15:0] c1, input logic [15:0] c2,
                      input logic [15:0] cnt);
    wr(ACTL, ctl(0, 1, 1, 2'b00, 4'd0));
    wr(AC1, c1); wr(AC2, c2); wr(ACNT, cnt);
  endtask

  task automatic finish_up;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk); cycles++;
      if (cycles > 150000) begin
        checks++; fails++;
        $display("FAIL watchdog: actual %0d expected <150000", cycles);
        finish_up();
      end
    end
  end

  task automatic t_reset;
    logic [15:0] d;
    rd(AC1, d);  check("R1 cmp1", d, 16'h0);
    rd(AC2, d);  check("R1 cmp2", d, 16'h0);
    rd(ACNT, d); check("R1 cnt", d, 16'h0);
    rd(ACTL, d); check("R1 ctrl", d, 16'h0);
    check("R1 irq", {15'b0, irq}, 16'h0);
  endtask

  task automatic t_gate;
    logic [15:0] d;
    prep(16'hFFF0, 16'hFFF0, 16'h0010);
    rd(ACNT, d); check("R5 cnt load", d, 16'h0010);
    pulse(5);
    rd(ACNT, d); check("R2 disabled hold", d, 16'h0010);
    wr(ACTL, ctl(1, 0, 0, 2'b00, 4'd0));
    pulse(3);
    rd(ACNT, d); check("R2 enabled count", d, 16'h0013);
    wr(ACTL, ctl(0, 0, 0, 2'b00, 4'd0));
    pulse(4);
    rd(ACNT, d); check("R2 stopped", d, 16'h0013);
  endtask

  task automatic t_prescale;
    logic [15:0] d;
    prep(16'hFFF0, 16'hFFF0, 16'h0000);
    wr(ACTL, ctl(1, 0, 0, 2'b00, 4'd2));
    pulse(3);
    rd(ACNT, d); check("R3 div4 partial", d, 16'h0000);
    pulse(1);
    rd(ACNT, d); check("R3 div4 first", d, 16'h0001);
    pulse(2);
    wr(ACNT, 16'h0005);
    pulse(3);
    rd(ACNT, d); check("R3 restart on write", d, 16'h0005);
    pulse(1);
    rd(ACNT, d); check("R3 full period after write", d, 16'h0006);
  endtask

  task automatic t_clamp;
    logic [15:0] d;
    prep(16'hFFF0, 16'hFFF0, 16'h0000);
    wr(ACTL, ctl(1, 0, 0, 2'b00, 4'd15));
    pulse(255);
    rd(ACNT, d); check("R4 clamp partial", d, 16'h0000);
    pulse(1);
    rd(ACNT, d); check("R4 clamp div256", d, 16'h0001);
    rd(ACTL, d); check("R5 ctrl readback", d, ctl(1, 0, 0, 2'b00, 4'd15));
  endtask

  task automatic t_match;
    logic [15:0] d;
    prep(16'h0002, 16'h0003, 16'h0000);
    rd(AC1, d); check("R5 cmp1 readback", d, 16'h0002);
    rd(AC2, d); check("R5 cmp2 readback", d, 16'h0003);
    wr(ACTL, ctl(1, 0, 0, 2'b11, 4'd0));
    pulse(3);
    rd(ACTL, d); check("R7 cmp1 flag", d, ctl(1, 0, 1, 2'b11, 4'd0));
    rd(ACNT, d); check("R7 continues", d, 16'h0003);
    check("R9 irq low before", {15'b0, irq}, 16'h0);
    pulse(1);
    rd(ACNT, d); check("R6 wrap to 0", d, 16'h0000);
    rd(ACTL, d); check("R6 cmp2 flag", d, ctl(1, 1, 1, 2'b11, 4'd0));
    check("R9 irq high", {15'b0, irq}, 16'h1);
    wr(ACTL, ctl(1, 0, 0, 2'b11, 4'd0));
    rd(ACTL, d); check("R8 write 0 keeps", d, ctl(1, 1, 1, 2'b11, 4'd0));
    wr(ACTL, ctl(1, 0, 0, 2'b01, 4'd0));
    check("R9 irq mode 1", {15'b0, irq}, 16'h0);
    wr(ACTL, ctl(1, 0, 0, 2'b11, 4'd0));
    check("R9 irq level held", {15'b0, irq}, 16'h1);
    wr(ACTL, ctl(0, 1, 1, 2'b11, 4'd0));
    rd(ACTL, d); check("R8 one-write stop+ack", d, ctl(0, 0, 0, 2'b11, 4'd0));
    check("R9 irq cleared", {15'b0, irq}, 16'h0);
  endtask

  task automatic t_bounds;
    logic [15:0] d;
    prep(16'hFFFF, 16'h000F, 16'h0000);
    wr(ACTL, ctl(1, 0, 0, 2'b00, 4'd0));
    pulse(15);
    rd(ACTL, d); check("R10 min no early match", d[14], 1'b0);
    pulse(1);
    rd(ACTL, d); check("R10 min match", d[14], 1'b1);
    wr(ACTL, ctl(1, 1, 0, 2'b00, 4'd0));
    pulse(15);
    rd(ACTL, d); check("R10 one per interval", d[14], 1'b0);
    pulse(1);
    rd(ACTL, d); check("R10 second interval", d[14], 1'b1);
    prep(16'h0000, 16'hFFFE, 16'hFFFC);
    wr(ACTL, ctl(1, 0, 0, 2'b00, 4'd0));
    pulse(2);
    rd(ACNT, d); check("R10 max reached", d, 16'hFFFE);
    rd(ACTL, d); check("R10 max no flag", d[14], 1'b0);
    pulse(1);
    rd(ACTL, d); check("R10 max match", d[14], 1'b1);
    rd(ACNT, d); check("R10 max wrap", d, 16'h0000);
  endtask

  task automatic t_wrap;
    logic [15:0] d;
    prep(16'h1000, 16'h1000, 16'hFFFF);
    wr(ACTL, ctl(1, 0, 0, 2'b00, 4'd0));
    pulse(1);
    rd(ACNT, d); check("R11 wrap", d, 16'h0000);
    rd(ACTL, d); check("R11 no flag", d[14:13], 2'b00);
  endtask

  task automatic t_race;
    logic [15:0] d;
    prep(16'hFFF0, 16'h0002, 16'h0000);
    wr(ACTL, ctl(1, 0, 0, 2'b11, 4'd0));
    pulse(2);
    @(negedge clk);
    bus_addr = ACTL; bus_wdata = ctl(1, 1, 0, 2'b11, 4'd0);
    bus_wr = 1'b1; ref_tick = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; ref_tick = 1'b0;
    rd(ACTL, d); check("R12 set wins", d[14], 1'b1);
    check("R12 irq stays", {15'b0, irq}, 16'h1);
    rd(ACNT, d); check("R12 wrap", d, 16'h0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_gate();
    t_prescale();
    t_clamp();
    t_match();
    t_bounds();
    t_wrap();
    t_race();
    finish_up();
  end
endmodule